// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block is a small receive queue that sits between the frame store path of a CAN controller and the software that consumes received messages. Each slot holds a complete message: identifier, data length code and up to eight data bytes. The frame store path offers a finished message with a single-cycle push strobe. Software reads the oldest message from the head outputs and frees it by writing a self-clearing release bit, which appears here as a one-cycle pulse.

The queue keeps a write pointer to the next free slot, a read pointer to the oldest unreleased message, and a pending count that software can read. A push and a release may arrive in the same cycle at any fill level. Both are then resolved against the same old state, so neither pointer update is lost. A message that arrives while every slot is occupied is discarded and raises a sticky overrun flag. The depth defaults to three slots, and the pointers wrap modulo the depth.

Top module: `rxmb_fifo`

## Requirements
- R1: After reset the pending count is 0, both pointers are 0, and the full and overrun flags are 0.
- R2: A push accepted while the count is below the depth stores the message at the write pointer. The write pointer then advances modulo the depth (0, 1, 2, 0 with the default depth of 3), and the count rises by one on the next clock edge.
- R3: A release while the count is non-zero advances the read pointer modulo the depth and lowers the count by one. The head outputs always present the slot at the read pointer.
- R4: The pending count stays within 0 to the depth. The full flag is 1 exactly when the count equals the depth.
- R5: A push while the count equals the depth is discarded. The write pointer, the count and the stored messages are unchanged, and the overrun flag becomes 1.
- R6: The overrun flag stays set until a cycle with the clear input at 1 and no discarded push. When both happen in the same cycle, setting wins.
- R7: A push and a release in the same cycle with the count at 1 or 2 advance both pointers and leave the count unchanged. No stored message is overwritten.
- R8: A release while the count is 0 is ignored and changes no state.
- R9: Whenever the count is 0, the write pointer equals the read pointer, whatever sequence led there.
- R10: A push and a release in the same cycle while full: the release takes effect, the push is discarded, and overrun is set.
- R11: A push and a release in the same cycle while empty: the push is stored, the release is ignored, and the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | One-cycle strobe offering a received message |
| rx_id | input | ID_W | Identifier of the offered message |
| rx_dlc | input | DLC_W | Data length code of the offered message |
| rx_data | input | 8*DATA_BYTES | Data bytes of the offered message |
| sw_release | input | 1 | Release pulse from the self-clearing software bit |
| sw_ovr_clr | input | 1 | Write-one clear of the overrun flag |
| hd_id | output | ID_W | Identifier of the slot at the read pointer |
| hd_dlc | output | DLC_W | Data length code of the slot at the read pointer |
| hd_data | output | 8*DATA_BYTES | Data bytes of the slot at the read pointer |
| pend_cnt | output | CNT_W | Number of pending messages |
| wr_ptr | output | PTR_W | Next slot to be written |
| rd_ptr | output | PTR_W | Oldest unreleased slot |
| fifo_full | output | 1 | Count equals depth |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
A pointer that misses an update shows up at the ports as a mismatch between the pointer difference and the pending count, in the cycle right after the faulty edge. Once the count returns to 0, the same fault leaves the two pointers unequal. Data damage from a lost write-pointer step appears only later, when the overwritten slot reaches the head. For that reason the bench compares the head fields against a message-by-message model on every cycle that has messages pending. It also sweeps every four-operation sequence of push, release and clear from reset, so every fill level meets every combination of coinciding requests.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
   localparam int MIN_DLC_W = 4;
   localparam int MAX_BYTES = 8;
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2
   } cnt_move_e;
endpackage

// File: rtl/rxmb_ptr.sv
module rxmb_ptr #(
   parameter int DEPTH = 3,
   parameter int PTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   logic [PTR_W-1:0] ptr_q, ptr_nx;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         always_comb ptr_nx = ptr_q + PTR_W'(1);
      end else begin : g_mod
         always_comb ptr_nx = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (step) ptr_q <= ptr_nx;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store #(
   parameter int DEPTH  = 3,
   parameter int PTR_W  = 2,
   parameter int SLOT_W = 97
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [SLOT_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [SLOT_W-1:0] rdata
);
   logic [SLOT_W-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && waddr == PTR_W'(s)) slot_q[s] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int s = 0; s < DEPTH; s++) begin
         if (raddr == PTR_W'(s)) rdata = slot_q[s];
      end
   end
endmodule

// File: rtl/rxmb_count.sv
module rxmb_count
   import rxmb_pkg::*;
#(
   parameter int DEPTH = 3,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic             ovr_clr,
   output logic             push_ok,
   output logic             pop_ok,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             overrun
);
   logic [CNT_W-1:0] cnt_q;
   logic             ovr_q;
   cnt_move_e        move;

   always_comb begin
      full    = (cnt_q == CNT_W'(DEPTH));
      push_ok = push_req && !full;
      pop_ok  = pop_req && (cnt_q != '0);
      case ({push_ok, pop_ok})
         2'b10:   move = CNT_UP;
         2'b01:   move = CNT_DOWN;
         default: move = CNT_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         case (move)
            CNT_UP:   cnt_q <= cnt_q + CNT_W'(1);
            CNT_DOWN: cnt_q <= cnt_q - CNT_W'(1);
            default:  cnt_q <= cnt_q;
         endcase
         if (push_req && full) ovr_q <= 1'b1;
         else if (ovr_clr)     ovr_q <= 1'b0;
      end
   end

   assign cnt     = cnt_q;
   assign overrun = ovr_q;
endmodule

// File: rtl/rxmb_fifo.sv
module rxmb_fifo
   import rxmb_pkg::*;
#(
   parameter int DEPTH      = 3,
   parameter int ID_W       = 29,
   parameter int DLC_W      = 4,
   parameter int DATA_BYTES = 8,
   localparam int DATA_W    = 8 * DATA_BYTES,
   localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_push,
   input  logic [ID_W-1:0]   rx_id,
   input  logic [DLC_W-1:0]  rx_dlc,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              sw_release,
   input  logic              sw_ovr_clr,
   output logic [ID_W-1:0]   hd_id,
   output logic [DLC_W-1:0]  hd_dlc,
   output logic [DATA_W-1:0] hd_data,
   output logic [CNT_W-1:0]  pend_cnt,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              fifo_full,
   output logic              ovr_flag
);
   localparam int SLOT_W = ID_W + DLC_W + DATA_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxmb_fifo: DEPTH must be at least 2");
      end
      if (DATA_BYTES < 1 || DATA_BYTES > MAX_BYTES) begin : g_bad_bytes
         $error("rxmb_fifo: DATA_BYTES out of range");
      end
      if (DLC_W < MIN_DLC_W) begin : g_bad_dlc
         $error("rxmb_fifo: DLC_W too narrow");
      end
   endgenerate

   logic              push_ok, pop_ok;
   logic [SLOT_W-1:0] wslot, rslot;

   rxmb_count #(.DEPTH(DEPTH), .CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .push_req(rx_push), .pop_req(sw_release),
      .ovr_clr(sw_ovr_clr), .push_ok(push_ok), .pop_ok(pop_ok),
      .cnt(pend_cnt), .full(fifo_full), .overrun(ovr_flag)
   );

   rxmb_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) wptr_i (
      .clk(clk), .rst_n(rst_n), .step(push_ok), .ptr(wr_ptr)
   );

   rxmb_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) rptr_i (
      .clk(clk), .rst_n(rst_n), .step(pop_ok), .ptr(rd_ptr)
   );

   assign wslot = {rx_id, rx_dlc, rx_data};

   rxmb_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .SLOT_W(SLOT_W)) store_i (
      .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wslot),
      .raddr(rd_ptr), .rdata(rslot)
   );

   assign {hd_id, hd_dlc, hd_data} = rslot;
endmodule

// File: rtl/rxmb_fifo_chk.sv
module rxmb_fifo_chk #(
   parameter int DEPTH = 3,
   parameter int PTR_W = 2,
   parameter int CNT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_push,
   input logic             sw_release,
   input logic             sw_ovr_clr,
   input logic [CNT_W-1:0] pend_cnt,
   input logic [PTR_W-1:0] wr_ptr,
   input logic [PTR_W-1:0] rd_ptr,
   input logic             fifo_full,
   input logic             ovr_flag
);
   int gap;
   always_comb gap = (int'(wr_ptr) + DEPTH - int'(rd_ptr)) % DEPTH;

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pend_cnt) <= DEPTH);

   // R9
   empty_ptr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_cnt == '0) |-> (wr_ptr == rd_ptr));

   // R2
   ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap == (int'(pend_cnt) % DEPTH));

   // R5
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && fifo_full) |=> ($stable(wr_ptr) && ovr_flag));

   // R7
   coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && sw_release && pend_cnt != '0 && !fifo_full)
      |=> ($stable(pend_cnt) && wr_ptr != $past(wr_ptr) && rd_ptr != $past(rd_ptr)));

   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_release && !rx_push && pend_cnt == '0)
      |=> ($stable(pend_cnt) && $stable(rd_ptr) && $stable(wr_ptr)));

   // R6
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !sw_ovr_clr) |=> ovr_flag);
endmodule

bind rxmb_fifo rxmb_fifo_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .sw_release(sw_release),
   .sw_ovr_clr(sw_ovr_clr), .pend_cnt(pend_cnt), .wr_ptr(wr_ptr),
   .rd_ptr(rd_ptr), .fifo_full(fifo_full), .ovr_flag(ovr_flag)
);

// File: tb/rxmb_fifo_tb_top.sv
`timescale 1ns/1ps
module rxmb_fifo_tb_top;
   localparam int DEPTH = 3;
   localparam int ID_W = 29;
   localparam int DLC_W = 4;
   localparam int DW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_push = 1'b0, sw_release = 1'b0, sw_ovr_clr = 1'b0;
   logic [ID_W-1:0]  rx_id = '0;
   logic [DLC_W-1:0] rx_dlc = '0;
   logic [DW-1:0]    rx_data = '0;
   logic [ID_W-1:0]  hd_id;
   logic [DLC_W-1:0] hd_dlc;
   logic [DW-1:0]    hd_data;
   logic [1:0] pend_cnt, wr_ptr, rd_ptr;
   logic fifo_full, ovr_flag;

   always #2.5 clk = ~clk;

   rxmb_fifo dut_i (.*);

   int vectors = 0, errs = 0;
   logic [ID_W-1:0]  m_id [DEPTH];
   logic [DLC_W-1:0] m_dlc [DEPTH];
   logic [DW-1:0]    m_data [DEPTH];
   int m_wr, m_rd, m_cnt;
   logic m_ovr;

   task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rx_push = 0; sw_release = 0; sw_ovr_clr = 0;
      @(negedge clk);
      rst_n = 1'b1;
      m_wr = 0; m_rd = 0; m_cnt = 0; m_ovr = 0;
      #1;
      chk("R1", "cnt", 128'(pend_cnt), 0);
      chk("R1", "wr", 128'(wr_ptr), 0);
      chk("R1", "rd", 128'(rd_ptr), 0);
      chk("R1", "full", 128'(fifo_full), 0);
      chk("R1", "ovr", 128'(ovr_flag), 0);
   endtask

   task automatic step(int op, logic [15:0] p);
      logic ps, rl, cl, acc_ps, acc_rl;
      string tag;
      ps = op[0]; rl = op[1]; cl = op[2];
      @(negedge clk);
      rx_push = ps; sw_release = rl; sw_ovr_clr = cl;
      rx_id = {13'h0a5, p}; rx_dlc = p[3:0];
      rx_data = {4{p}} ^ 64'h0123_4567_89ab_cdef;
      if (ps && rl && m_cnt == 2)      tag = "R7";
      else if (ps && rl && m_cnt == 1) tag = "R7";
      else if (ps && rl && m_cnt == 3) tag = "R10";
      else if (ps && rl && m_cnt == 0) tag = "R11";
      else if (ps && m_cnt == 3)       tag = "R5";
      else if (rl && m_cnt == 0)       tag = "R8";
      else if (ps)                     tag = "R2";
      else if (rl)                     tag = "R3";
      else                             tag = "R4";
      acc_ps = ps && (m_cnt < DEPTH);
      acc_rl = rl && (m_cnt > 0);
      if (acc_ps) begin
         m_id[m_wr] = rx_id; m_dlc[m_wr] = rx_dlc; m_data[m_wr] = rx_data;
         m_wr = (m_wr + 1) % DEPTH;
      end
      if (acc_rl) m_rd = (m_rd + 1) % DEPTH;
      if (ps && m_cnt == DEPTH) m_ovr = 1'b1;
      else if (cl) m_ovr = 1'b0;
      m_cnt = m_cnt + int'(acc_ps) - int'(acc_rl);
      @(posedge clk);
      #1;
      rx_push = 0; sw_release = 0; sw_ovr_clr = 0;
      chk(tag, "cnt", 128'(pend_cnt), 128'(m_cnt));
      chk(tag, "wr", 128'(wr_ptr), 128'(m_wr));
      chk(tag, "rd", 128'(rd_ptr), 128'(m_rd));
      chk("R4", "full", 128'(fifo_full), 128'(m_cnt == DEPTH));
      chk((ps && m_cnt == DEPTH) ? "R5" : "R6", "ovr", 128'(ovr_flag), 128'(m_ovr));
      if (m_cnt > 0) begin
         chk(tag, "head id", 128'(hd_id), 128'(m_id[m_rd]));
         chk(tag, "head dlc", 128'(hd_dlc), 128'(m_dlc[m_rd]));
         chk(tag, "head data", 128'(hd_data), 128'(m_data[m_rd]));
      end else begin
         chk("R9", "ptr equal when empty", 128'(wr_ptr), 128'(rd_ptr));
      end
   endtask

   initial begin
      for (int seq = 0; seq < 4096; seq++) begin
         do_reset();
         for (int k = 0; k < 4; k++) begin
            step((seq >> (3 * k)) & 7, {seq[11:0], 4'(k)});
         end
      end
      // long mixed run without reset: wrap-around of both pointers
      for (int k = 0; k < 600; k++) begin
         step((k * 5 + k / 7) & 7, 16'(k));
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule